// File: doc/BRIEF.md
# Selectable-Register Sine Synthesizer

This block is a numerically controlled oscillator. A 32-bit phase accumulator adds a frequency tuning word on every clock. The output frequency is `tuning_word * f_clk / 2^32`, so the resolution is one part in 2^32. A word of 0x5671C71C at a 6.25 MHz clock gives about 2.11 MHz. The top 12 bits of the accumulator are added to a 12-bit phase offset. The sum addresses a quarter-wave sine table that returns a 10-bit offset-binary sample.

The block holds two tuning words and four phase offsets. The pins `fsel` and `psel` choose the active tuning word and the active phase offset on every clock. Switching them at run time gives frequency-shift and phase-shift keying without any reload. All registers are written through a three-wire serial port framed by `fsync_n`. A control command puts the core into power-down, where the output rests at mid-scale and the stored words are kept.

Top module: `nco_selreg`

## Requirements
- R1: While reset is high and in the first cycle after it, `sample` is 0x200, and every tuning word, phase offset and the power-down flag are zero.
- R2: `sclk`, `sdata` and `fsync_n` are re-timed through two flip-flops. While the re-timed `fsync_n` is low, each falling `sclk` edge shifts in one bit, MSB first, and the 16th bit completes a frame. If `fsync_n` goes high before 16 bits have arrived, the partial frame is discarded.
- R3: The frame bits [15:12] form the command and bits [11:0] form the data. Command 0fpp writes tuning word f in parts. Part 0 stores data into staging bits [11:0] and part 1 stores data into staging bits [23:12]; the staging register is shared. Part 2 writes {data[7:0], staging} to word f. Part 3 is ignored. A tuning word never changes on any frame except part 2.
- R4: Command 10pp writes data[11:0] into phase offset pp in a single frame.
- R5: Command 1100 sets power-down to data[0]. Commands 1101, 1110 and 1111 have no effect.
- R6: On every clock the accumulator adds the tuning word chosen by the registered `fsel`, modulo 2^32. A select change does not reset the accumulated phase.
- R7: The table phase is the accumulator bits [31:20] plus the offset chosen by the registered `psel`, modulo 4096.
- R8: For table phase p, let a be p[9:0], inverted when p[10] is 1. Let m = round(511*sin((a+0.5)*pi/2048)). The sample is 0x200+m when p[11] is 0 and 0x1FF-m when p[11] is 1.
- R9: In power-down the accumulator is held at zero, and `sample` is 0x200 from the clock after the flag is set. When the flag clears, synthesis restarts from phase zero with the stored words.
- R10: Timing, counted in clock edges. A completed frame updates its register one edge after the 16th bit is detected. The accumulator, the phase stage, the table read and the output register each add one edge. A pin change on `fsel` or `psel` is captured at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial shift clock, idles high |
| sdata | input | 1 | Serial data, taken on falling `sclk` |
| fsync_n | input | 1 | Frame strobe, active low |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| sample | output | 10 | Offset-binary sine sample |

## Verification
The in-RTL properties check the following on every cycle:
- a completed frame produces a single write pulse;
- a tuning word changes only after a part-2 frame, and a phase offset only after a phase command;
- power-down forces mid-scale;
- the sign of the table phase decides which half of the code range the sample falls in.

Other behaviour needs the bench's scenarios, because only a full reference of the accumulator and the table can expose it:
- the exact sample values;
- accumulator continuity across `fsel` toggles;
- rejection of aborted frames and reserved commands;
- restart from phase zero after power-down.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int FRAME_W  = 16;
  localparam int CMD_W    = 4;
  localparam int DATA_W   = FRAME_W - CMD_W;
  localparam int FSEL_W   = 1;
  localparam int PSEL_W   = 2;
  localparam int NUM_FREQ = 1 << FSEL_W;
  localparam int NUM_POFF = 1 << PSEL_W;
  localparam logic [1:0]       OP_POFF  = 2'b10;
  localparam logic [CMD_W-1:0] CMD_CTRL = 4'b1100;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/nco_serial_loader.sv
module nco_serial_loader
  import nco_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sclk,
  input  logic   sdata,
  input  logic   fsync_n,
  output logic   wr_vld,
  output frame_t wr_frame
);
  localparam int CNT_W = $clog2(FRAME_W);

  // Bit order in the re-timing registers: {sclk, sdata, fsync_n}.
  logic [2:0] sync1, sync2;
  logic       sclk_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] shreg;
  logic               sclk_fall, in_frame, bit_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1  <= 3'b101;
      sync2  <= 3'b101;
      sclk_d <= 1'b1;
    end else begin
      sync1  <= {sclk, sdata, fsync_n};
      sync2  <= sync1;
      sclk_d <= sync2[2];
    end
  end

  assign sclk_fall = sclk_d & ~sync2[2];
  assign in_frame  = ~sync2[0];
  assign bit_in    = sync2[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      shreg    <= '0;
      wr_vld   <= 1'b0;
      wr_frame <= '0;
    end else begin
      wr_vld <= 1'b0;
      if (!in_frame) begin
        cnt <= '0;
      end else if (sclk_fall) begin
        shreg <= {shreg[FRAME_W-3:0], bit_in};
        if (cnt == CNT_W'(FRAME_W-1)) begin
          cnt      <= '0;
          wr_vld   <= 1'b1;
          wr_frame <= frame_t'({shreg, bit_in});
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: a frame yields exactly one write strobe
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_vld |=> !wr_vld);
endmodule

// File: rtl/nco_reg_bank.sv
module nco_reg_bank
  import nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  frame_t            wr_frame,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [PSEL_W-1:0] psel,
  output logic [ACC_W-1:0]  freq_act,
  output logic [PH_W-1:0]   poff_act,
  output logic              pd
);
  localparam int NPART = (ACC_W + DATA_W - 1) / DATA_W;
  localparam int STG_W = (NPART - 1) * DATA_W;
  localparam logic [1:0] PART_LAST = 2'(NPART - 1);

  logic [ACC_W-1:0]  freq_q [NUM_FREQ];
  logic [PH_W-1:0]   poff_q [NUM_POFF];
  logic [STG_W-1:0]  stage;
  logic [FSEL_W-1:0] fsel_q;
  logic [PSEL_W-1:0] psel_q;
  logic [FSEL_W-1:0] fidx;
  logic [PSEL_W-1:0] pidx;
  logic [1:0]        part;

  assign fidx = wr_frame.cmd[PSEL_W +: FSEL_W];
  assign pidx = wr_frame.cmd[PSEL_W-1:0];
  assign part = wr_frame.cmd[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_FREQ; i++) freq_q[i] <= '0;
      for (int i = 0; i < NUM_POFF; i++) poff_q[i] <= '0;
      stage  <= '0;
      pd     <= 1'b0;
      fsel_q <= '0;
      psel_q <= '0;
    end else begin
      fsel_q <= fsel;
      psel_q <= psel;
      if (wr_vld) begin
        if (!wr_frame.cmd[CMD_W-1]) begin
          if (part == PART_LAST)
            freq_q[fidx] <= ACC_W'({wr_frame.data, stage});
          else if (part < PART_LAST)
            stage[int'(part)*DATA_W +: DATA_W] <= wr_frame.data;
        end else if (wr_frame.cmd[CMD_W-1 -: 2] == OP_POFF) begin
          poff_q[pidx] <= wr_frame.data[PH_W-1:0];
        end else if (wr_frame.cmd == CMD_CTRL) begin
          pd <= wr_frame.data[0];
        end
      end
    end
  end

  assign freq_act = freq_q[fsel_q];
  assign poff_act = poff_q[psel_q];

  for (genvar g = 0; g < NUM_FREQ; g++) begin : g_fchk
    // R3: a tuning word moves only after a final-part frame
    a_r3_freq_commit_only: assert property (@(posedge clk) disable iff (rst)
      !$stable(freq_q[g]) |-> $past(wr_vld && !wr_frame.cmd[CMD_W-1] && part == PART_LAST));
  end
  for (genvar g = 0; g < NUM_POFF; g++) begin : g_pchk
    // R4: an offset moves only after a phase command
    a_r4_poff_write_only: assert property (@(posedge clk) disable iff (rst)
      !$stable(poff_q[g]) |-> $past(wr_vld && wr_frame.cmd[CMD_W-1 -: 2] == OP_POFF));
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd,
  input  logic [ACC_W-1:0] freq_act,
  input  logic [PH_W-1:0]  poff_act,
  output logic [PH_W-1:0]  phase
);
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      phase <= '0;
    end else begin
      acc   <= pd ? '0 : acc + freq_act;
      phase <= acc[ACC_W-1 -: PH_W] + poff_act;
    end
  end
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
  parameter int PH_W   = 12,
  parameter int SAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   phase,
  output logic [SAMP_W-2:0] mag,
  output logic              sign
);
  localparam int  QA_W  = PH_W - 2;
  localparam int  DEPTH = 1 << QA_W;
  localparam int  MAG_W = SAMP_W - 1;
  localparam real AMP   = real'((1 << MAG_W) - 1);
  localparam real PI    = 3.14159265358979;

  logic [MAG_W-1:0] rom [DEPTH];
  logic [QA_W-1:0]  addr;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = MAG_W'($rtoi(AMP * $sin((real'(i) + 0.5) * PI / (2.0 * real'(DEPTH))) + 0.5));
  end

  assign addr = phase[QA_W] ? ~phase[QA_W-1:0] : phase[QA_W-1:0];

  always_ff @(posedge clk) begin
    mag <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) sign <= 1'b0;
    else     sign <= phase[PH_W-1];
  end
endmodule

// File: rtl/nco_selreg.sv
module nco_selreg
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 12,
  parameter int SAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              fsync_n,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [PSEL_W-1:0] psel,
  output logic [SAMP_W-1:0] sample
);
  localparam logic [SAMP_W-1:0] MID = SAMP_W'(1) << (SAMP_W - 1);

  logic             wr_vld;
  frame_t           wr_frame;
  logic [ACC_W-1:0] freq_act;
  logic [PH_W-1:0]  poff_act;
  logic             pd;
  logic [PH_W-1:0]  phase;
  logic [SAMP_W-2:0] mag;
  logic             sign;

  nco_serial_loader u_loader (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .fsync_n(fsync_n),
    .wr_vld(wr_vld), .wr_frame(wr_frame)
  );

  nco_reg_bank #(.ACC_W(ACC_W), .PH_W(PH_W)) u_bank (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_frame(wr_frame),
    .fsel(fsel), .psel(psel),
    .freq_act(freq_act), .poff_act(poff_act), .pd(pd)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst(rst), .pd(pd), .freq_act(freq_act), .poff_act(poff_act),
    .phase(phase)
  );

  nco_sine_lut #(.PH_W(PH_W), .SAMP_W(SAMP_W)) u_lut (
    .clk(clk), .rst(rst), .phase(phase), .mag(mag), .sign(sign)
  );

  always_ff @(posedge clk) begin
    if (rst || pd) sample <= MID;
    else if (sign) sample <= MID - SAMP_W'(1) - {1'b0, mag};
    else           sample <= MID + {1'b0, mag};
  end

  // R9: power-down parks the output at mid-scale
  a_r9_idle_midscale: assert property (@(posedge clk) disable iff (rst)
    pd |=> sample == MID);
  // R8: negative half-wave stays below mid-scale
  a_r8_lower_half: assert property (@(posedge clk) disable iff (rst)
    (!pd && sign) |=> sample < MID);
  // R8: positive half-wave stays at or above mid-scale
  a_r8_upper_half: assert property (@(posedge clk) disable iff (rst)
    (!pd && !sign) |=> sample >= MID);
endmodule

// File: tb/test_nco_selreg.sv
module test_nco_selreg;
  localparam int MID = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b1, sdata = 1'b0, fsync_n = 1'b1, fsel = 1'b0;
  logic [1:0] psel = 2'd0;
  logic [9:0] sample;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    checking = 1'b0;

  always #5 clk = ~clk;

  nco_selreg i_nco_selreg (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .fsync_n(fsync_n),
    .fsel(fsel), .psel(psel), .sample(sample)
  );

  // R8 table computed from the requirement formula
  int tbl [1024];
  initial begin
    for (int i = 0; i < 1024; i++)
      tbl[i] = $rtoi(511.0 * $sin((real'(i) + 0.5) * 3.14159265358979 / 2048.0) + 0.5);
  end

  // Behavioural reference model
  bit [2:0]  m_s1, m_s2;
  bit        m_d3, m_wv, m_pd, m_fsel, m_sign, fall;
  int        m_cnt, m_sh, m_ww, m_stage, m_psel, m_phase, m_mag, m_dout, nb, addr, cmd, dat;
  bit [31:0] m_freq [2];
  int        m_poff [4];
  bit [31:0] m_acc;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 3'b101; m_s2 = 3'b101; m_d3 = 1; m_wv = 0; m_ww = 0; m_cnt = 0; m_sh = 0;
      m_freq[0] = 0; m_freq[1] = 0;
      for (int i = 0; i < 4; i++) m_poff[i] = 0;
      m_stage = 0; m_pd = 0; m_fsel = 0; m_psel = 0; m_acc = 0; m_phase = 0;
      m_mag = tbl[0]; m_sign = 0; m_dout = MID;
    end else begin
      m_dout  = m_pd ? MID : (m_sign ? MID - 1 - m_mag : MID + m_mag);
      m_sign  = m_phase[11];
      addr    = m_phase[10] ? ((~m_phase) & 1023) : (m_phase & 1023);
      m_mag   = tbl[addr];
      m_phase = (int'(m_acc >> 20) + m_poff[m_psel]) & 4095;
      m_acc   = m_pd ? 32'd0 : m_acc + m_freq[m_fsel];
      m_fsel  = fsel;
      m_psel  = int'(psel);
      if (m_wv) begin
        cmd = (m_ww >> 12) & 15;
        dat = m_ww & 4095;
        if (cmd < 8) begin
          if ((cmd & 3) == 0)      m_stage = (m_stage & 32'hFFF000) | dat;
          else if ((cmd & 3) == 1) m_stage = (m_stage & 32'h000FFF) | (dat << 12);
          else if ((cmd & 3) == 2) m_freq[(cmd >> 2) & 1] = {dat[7:0], m_stage[23:0]};
        end else if (cmd < 12) m_poff[cmd & 3] = dat;
        else if (cmd == 12)    m_pd = dat[0];
      end
      fall = m_d3 && !m_s2[2];
      m_wv = 0;
      if (m_s2[0]) m_cnt = 0;
      else if (fall) begin
        nb = (m_sh << 1) | int'(m_s2[1]);
        if (m_cnt == 15) begin m_cnt = 0; m_wv = 1; m_ww = nb & 16'hFFFF; end
        else m_cnt++;
        m_sh = nb & 16'h7FFF;
      end
      m_d3 = m_s2[2];
      m_s2 = m_s1;
      m_s1 = {sclk, sdata, fsync_n};
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (checking && !rst) begin
      n_chk++;
      if (sample !== 10'(m_dout)) begin
        n_fail++;
        $display("FAIL %s: sample=%0d expected=%0d", cur_req, sample, m_dout);
      end
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits);
    @(negedge clk) fsync_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 15; i > 15 - nbits; i--) begin
      sdata = w[i]; sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    fsync_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_freq(input bit idx, input logic [31:0] v);
    send_frame({1'b0, idx, 2'd0, v[11:0]}, 16);
    send_frame({1'b0, idx, 2'd1, v[23:12]}, 16);
    send_frame({1'b0, idx, 2'd2, 4'h0, v[31:24]}, 16);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    checking = 1'b1;
    cur_req = "R1";
    check_eq("R1", int'(sample), MID);
    idle(20);
    check_eq("R1", int'(sample), MID);

    cur_req = "R4";
    send_frame({4'b1001, 12'h400}, 16);
    send_frame({4'b1010, 12'h800}, 16);
    send_frame({4'b1011, 12'hC00}, 16);

    cur_req = "R3";
    write_freq(1'b0, 32'h0123_4567);
    idle(200);

    cur_req = "R6";
    write_freq(1'b1, 32'h5671_C71C);
    for (int k = 0; k < 10; k++) begin
      fsel = ~fsel;
      idle(37);
    end
    fsel = 1'b0;

    cur_req = "R7/R10";
    for (int k = 0; k < 12; k++) begin
      psel = psel + 2'd1;
      idle(23);
    end
    psel = 2'd0;

    cur_req = "R3";
    send_frame({4'b0000, 12'hFFF}, 16);
    send_frame({4'b0001, 12'hFFF}, 16);
    idle(60);
    send_frame({4'b0011, 12'h5A5}, 16);
    idle(60);
    send_frame({4'b0010, 12'h004}, 16);

    cur_req = "R8";
    idle(300);

    cur_req = "R2";
    send_frame({4'b1001, 12'h123}, 8);
    psel = 2'd1;
    idle(80);
    send_frame({4'b1001, 12'h321}, 16);
    idle(80);

    cur_req = "R5";
    send_frame({4'b1101, 12'h001}, 16);
    send_frame({4'b1111, 12'hFFF}, 16);
    idle(80);

    cur_req = "R9";
    send_frame({4'b1100, 12'h001}, 16);
    idle(30);
    check_eq("R9", int'(sample), MID);
    fsel = 1'b1;
    idle(30);
    check_eq("R9", int'(sample), MID);
    send_frame({4'b1100, 12'h000}, 16);
    idle(200);

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end
endmodule